// File: doc/BRIEF.md
# Receive Destination Address Filter

This block makes the accept or reject decision for each received Ethernet frame from its 48-bit destination address. The receive path presents the destination address and the frame's 32-bit CRC with a one-cycle lookup strobe. One clock later the filter returns a verdict. Computing the CRC and holding the frame while the verdict is pending are handled outside this block.

The block holds two exact-match station addresses and a 512-bin multicast hash table. Frames are accepted in these cases:

- In promiscuous mode, every frame is accepted.
- A broadcast frame is always accepted.
- A multicast frame is accepted when the hash bin selected by the top nine CRC bits is set.
- A unicast frame is accepted when it matches one of the station addresses.

Software programs the filter through a simple write port. A 3-bit select picks the target, and a 32-bit data word carries the value.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset the following state holds. `result_valid` is 0. Every hash bin is clear. The primary station address is all zeros. The secondary station address is inactive.
- R2: `result_valid` is 1 exactly in the cycle after a cycle with `lookup_valid` high, and 0 otherwise. `result_accept` carries the verdict for that lookup.
- R3: When `promisc_en` is 1 during a lookup, the frame is accepted whatever its address or CRC.
- R4: A destination address of all ones (broadcast) is accepted even when promiscuous mode is off and no hash bin is set.
- R5: The primary station address is written in two parts. Select 0 writes its bits 31:0 from `cfg_wr_data[31:0]`. Select 1 writes its bits 47:32 from `cfg_wr_data[15:0]`. A unicast frame (address bit 40 clear) whose address equals the primary address is accepted. Any other unicast frame is rejected unless R6 accepts it.
- R6: Select 2 writes bits 31:0 of the secondary address, and select 3 writes bits 47:32 of it. A write to select 3 makes the secondary address active. Select 6 makes it inactive. A unicast frame equal to an active secondary address is accepted.
- R7: A non-broadcast frame with address bit 40 set is multicast. It is accepted exactly when the hash bin indexed by `lookup_crc[31:23]` (the CRC shifted right by 23) is set.
- R8: A write to select 4 updates one hash bin. The bin index is `cfg_wr_data[8:0]`. The bin is set when `cfg_wr_data[9]` is 1 and cleared when it is 0. No other bin changes.
- R9: A write to select 5 clears all 512 hash bins at once.
- R10: A write takes effect for lookups in later cycles only. A lookup in the same cycle as a write sees the state before that write. Select 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Write target select (see R5, R6, R8 to R10) |
| cfg_wr_data | input | 32 | Write data |
| promisc_en | input | 1 | Promiscuous mode |
| lookup_valid | input | 1 | Lookup strobe for one frame |
| lookup_da | input | 48 | Destination address, bit 40 is the group bit |
| lookup_crc | input | 32 | Frame CRC, top nine bits index the hash |
| result_valid | output | 1 | Verdict available |
| result_accept | output | 1 | 1 accepts the frame, 0 rejects it |

## Verification
Some cases are hard to reach because random 48-bit addresses almost never hit a programmed station address or a set hash bin. The stimulus therefore draws the destination from the programmed station values, from broadcast, and from the group and individual classes. It also draws CRC indices from a small pool that the random hash writes also target, so set and cleared bins are both probed often. Directed sequences cover two other cases. One writes the secondary address in halves and then deactivates it. The other issues a hash write and a lookup of the same bin in the same cycle.

// File: rtl/rdf_pkg.sv
// Shared definitions for the receive destination filter.
// Assumes the write select is three bits wide.
package rdf_pkg;

    typedef enum logic [2:0] {
        SEL_PRI_LO  = 3'd0,
        SEL_PRI_HI  = 3'd1,
        SEL_SEC_LO  = 3'd2,
        SEL_SEC_HI  = 3'd3,
        SEL_HASH    = 3'd4,
        SEL_CLR_TBL = 3'd5,
        SEL_CLR_SEC = 3'd6,
        SEL_NOP     = 3'd7
    } cfg_sel_e;

endpackage

// File: rtl/rdf_station.sv
// One exact-match station address register with comparator.
// Assumes a 48-bit address split into a 32-bit low half and an upper half.
// When ALWAYS_ON is set, the entry is permanently active and the clear
// input has no effect.
module rdf_station #(
    parameter int ADDR_W    = 48,
    parameter bit ALWAYS_ON = 1'b0,
    localparam int HI_W     = ADDR_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              clr,
    input  logic [31:0]       lo_data,
    input  logic [HI_W-1:0]   hi_data,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic              hit
);

    logic [ADDR_W-1:0] addr_q;
    logic              active_q;

    // Hold the programmed address halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            if (wr_lo) addr_q[31:0]       <= lo_data;
            if (wr_hi) addr_q[ADDR_W-1:32] <= hi_data;
        end
    end

    generate
        if (ALWAYS_ON) begin : g_fixed
            // Permanently active entry: the clear input is ignored.
            logic clr_unused;
            assign clr_unused = clr;
            assign active_q   = 1'b1;
        end else begin : g_switch
            logic act_r;
            // Activate on an upper-half write, deactivate on clear.
            always_ff @(posedge clk) begin
                if (!rst_n)     act_r <= 1'b0;
                else if (clr)   act_r <= 1'b0;
                else if (wr_hi) act_r <= 1'b1;
            end
            assign active_q = act_r;
        end
    endgenerate

    // Report an exact match of an active entry.
    always_comb hit = active_q && (cmp_addr == addr_q);

endmodule

// File: rtl/rdf_hash_bins.sv
// Multicast hash bit table.
// Supports a single-bin set or clear, a whole-table clear, and one
// combinational read port. Assumes the whole-table clear wins over a
// single-bin write in the same cycle.
module rdf_hash_bins #(
    parameter int IDX_W   = 9,
    localparam int NBINS  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_set,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    logic [NBINS-1:0] bins_q;

    // Update the bin vector.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) bins_q <= '0;
        else if (wr_en)        bins_q[wr_idx] <= wr_set;
    end

    // Read the bin addressed by the lookup.
    always_comb rd_bit = bins_q[rd_idx];

endmodule

// File: rtl/rdf_decide.sv
// Combinational verdict for one destination address.
// Checks are applied in this order: promiscuous, broadcast, then
// multicast hash, then unicast station match.
module rdf_decide #(
    parameter int ADDR_W = 48,
    parameter int NSTA   = 2,
    localparam int GRP_BIT = ADDR_W - 8
) (
    input  logic              promisc,
    input  logic [ADDR_W-1:0] da,
    input  logic [NSTA-1:0]   sta_hit,
    input  logic              bin_bit,
    output logic              accept
);

    logic is_bcast;
    logic is_group;

    // Classify the address and pick the rule that applies.
    always_comb begin
        is_bcast = &da;
        is_group = da[GRP_BIT];
        if (promisc)       accept = 1'b1;
        else if (is_bcast) accept = 1'b1;
        else if (is_group) accept = bin_bit;
        else               accept = |sta_hit;
    end

endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination address filter top.
// Decodes configuration writes, holds two station entries and the hash
// table, and registers one verdict per lookup with one cycle of latency.
// Assumes lookups and writes arrive on the same clock.
module rx_dest_filter #(
    parameter int ADDR_W = 48,
    parameter int CRC_W  = 32,
    parameter int IDX_W  = 9,
    localparam int NSTA  = 2,
    localparam int HI_W  = ADDR_W - 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    input  logic              promisc_en,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_da,
    input  logic [CRC_W-1:0]  lookup_crc,
    output logic              result_valid,
    output logic              result_accept
);
    import rdf_pkg::*;

    logic [NSTA-1:0]  sta_hit;
    logic             bin_bit;
    logic             verdict;
    logic [IDX_W-1:0] hash_idx;
    logic             crc_unused_bits;

    // Take the hash index from the top CRC bits.
    always_comb begin
        hash_idx        = lookup_crc[CRC_W-1 -: IDX_W];
        crc_unused_bits = ^lookup_crc[CRC_W-IDX_W-1:0];
    end

    generate
        for (genvar i = 0; i < NSTA; i++) begin : g_sta
            logic wlo, whi, wclr;
            // Decode the write strobes for this entry.
            always_comb begin
                wlo  = cfg_wr_en && (cfg_wr_sel == 3'(2*i));
                whi  = cfg_wr_en && (cfg_wr_sel == 3'(2*i+1));
                wclr = cfg_wr_en && (cfg_wr_sel == SEL_CLR_SEC) && (i != 0);
            end
            rdf_station #(
                .ADDR_W   (ADDR_W),
                .ALWAYS_ON(i == 0)
            ) sta_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_lo   (wlo),
                .wr_hi   (whi),
                .clr     (wclr),
                .lo_data (cfg_wr_data),
                .hi_data (cfg_wr_data[HI_W-1:0]),
                .cmp_addr(lookup_da),
                .hit     (sta_hit[i])
            );
        end
    endgenerate

    rdf_hash_bins #(.IDX_W(IDX_W)) bins_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en && (cfg_wr_sel == SEL_HASH)),
        .wr_idx (cfg_wr_data[IDX_W-1:0]),
        .wr_set (cfg_wr_data[IDX_W]),
        .clr_all(cfg_wr_en && (cfg_wr_sel == SEL_CLR_TBL)),
        .rd_idx (hash_idx),
        .rd_bit (bin_bit)
    );

    rdf_decide #(.ADDR_W(ADDR_W), .NSTA(NSTA)) dec_i (
        .promisc(promisc_en),
        .da     (lookup_da),
        .sta_hit(sta_hit),
        .bin_bit(bin_bit),
        .accept (verdict)
    );

    // Register the verdict alongside its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid  <= 1'b0;
            result_accept <= 1'b0;
        end else begin
            result_valid  <= lookup_valid;
            result_accept <= lookup_valid && verdict;
        end
    end

endmodule

// File: rtl/rdf_checker.sv
// Temporal properties of the destination filter, seen at its ports.
module rdf_checker #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [2:0]        cfg_wr_sel,
    input logic              promisc_en,
    input logic              lookup_valid,
    input logic [ADDR_W-1:0] lookup_da,
    input logic              result_valid,
    input logic              result_accept
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> result_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !result_valid);

    a_r3_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && promisc_en) |=> result_accept);

    a_r4_bcast_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && (&lookup_da)) |=> result_accept);

    a_r9_cleared_table_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_sel == 3'd5) ##1
        (lookup_valid && !promisc_en && lookup_da[ADDR_W-8] && !(&lookup_da))
        |=> (result_valid && !result_accept));

endmodule

bind rx_dest_filter rdf_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_sel   (cfg_wr_sel),
    .promisc_en   (promisc_en),
    .lookup_valid (lookup_valid),
    .lookup_da    (lookup_da),
    .result_valid (result_valid),
    .result_accept(result_accept)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [2:0]  cfg_wr_sel;
    logic [31:0] cfg_wr_data;
    logic        promisc_en;
    logic        lookup_valid;
    logic [47:0] lookup_da;
    logic [31:0] lookup_crc;
    logic        result_valid;
    logic        result_accept;

    always #5 clk = ~clk;

    rx_dest_filter dut_i (.*);

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [47:0]  m_sta [2];
    bit           m_sec_on;
    bit [511:0]   m_bins;

    function automatic bit exp_accept(bit p, logic [47:0] da, logic [31:0] crc);
        if (p) return 1'b1;
        if (&da) return 1'b1;
        if (da[40]) return m_bins[crc[31:23]];
        return (da == m_sta[0]) || (m_sec_on && da == m_sta[1]);
    endfunction

    function automatic void model_wr(logic [2:0] sel, logic [31:0] d);
        case (sel)
            3'd0: m_sta[0][31:0]  = d;
            3'd1: m_sta[0][47:32] = d[15:0];
            3'd2: m_sta[1][31:0]  = d;
            3'd3: begin m_sta[1][47:32] = d[15:0]; m_sec_on = 1'b1; end
            3'd4: m_bins[d[8:0]] = d[9];
            3'd5: m_bins = '0;
            3'd6: m_sec_on = 1'b0;
            default: ;
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_wr(sel, d);
    endtask

    // Lookup, optionally with a write in the same cycle (R10).
    task automatic look(string tag, bit p, logic [47:0] da, logic [31:0] crc,
                        bit do_wr = 0, logic [2:0] sel = 0, logic [31:0] d = 0);
        bit e;
        @(negedge clk);
        e = exp_accept(p, da, crc);
        promisc_en = p; lookup_valid = 1'b1; lookup_da = da; lookup_crc = crc;
        cfg_wr_en = do_wr; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        lookup_valid = 1'b0; cfg_wr_en = 1'b0;
        if (do_wr) model_wr(sel, d);
        check({tag, " valid (R2)"}, result_valid, 1'b1);
        check(tag, result_accept, e);
    endtask

    localparam logic [47:0] PRI = 48'h0A1B_2C3D_4E5E;
    localparam logic [47:0] SEC = 48'h3C00_1122_3344;
    localparam logic [47:0] MC  = 48'h0100_5E00_0001;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'h5EED_0001);
        m_sta[0] = '0; m_sta[1] = '0; m_sec_on = 0; m_bins = '0;
        rst_n = 0; cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0;
        promisc_en = 0; lookup_valid = 0; lookup_da = 0; lookup_crc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset valid", result_valid, 1'b0);
        look("R1 bins clear", 0, MC, 32'hFF80_0000);
        look("R1 primary zero", 0, 48'h0, 32'h0);
        @(negedge clk);
        check("R2 valid drops", result_valid, 1'b0);
        look("R1 secondary off", 0, 48'h0200_0000_0004, 32'h0);

        wr(3'd0, PRI[31:0]); wr(3'd1, {16'h0, PRI[47:32]});
        look("R5 primary match", 0, PRI, 32'h1234_5678);
        look("R5 primary miss", 0, PRI ^ 48'h1, 32'h0);

        wr(3'd2, SEC[31:0]);
        look("R6 half written", 0, SEC, 32'h0);
        wr(3'd3, {16'hFFFF, SEC[47:32]});
        look("R6 secondary match", 0, SEC, 32'h0);
        wr(3'd6, 32'h0);
        look("R6 secondary cleared", 0, SEC, 32'h0);
        look("R6 primary kept", 0, PRI, 32'h0);

        wr(3'd4, 32'h3FF);
        look("R7 bin hit", 0, MC, 32'hFF80_0000);
        look("R7 bin miss", 0, MC, 32'hFF00_0000);
        wr(3'd4, 32'h1FF);
        look("R8 bin cleared", 0, MC, 32'hFF80_0000);

        wr(3'd4, 32'h205); wr(3'd4, 32'h20A);
        look("R8 bin set", 0, MC, {9'h005, 23'h7FFFFF});
        wr(3'd5, 32'h0);
        look("R9 table cleared a", 0, MC, {9'h005, 23'h0});
        look("R9 table cleared b", 0, MC, {9'h00A, 23'h0});

        look("R3 promisc unicast", 1, 48'h0000_DEAD_BEEE, 32'h0);
        look("R3 promisc multicast", 1, MC, 32'h0);
        look("R4 broadcast", 0, 48'hFFFF_FFFF_FFFF, 32'h0);

        look("R10 same-cycle write", 0, MC, {9'h033, 23'h0}, 1, 3'd4, 32'h233);
        look("R10 after write", 0, MC, {9'h033, 23'h0});
        wr(3'd7, 32'hFFFF_FFFF);
        look("R10 nop select", 0, PRI, 32'h0);
        look("R10 nop bins", 0, MC, {9'h033, 23'h0});

        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                int s;
                logic [31:0] d;
                s = $urandom_range(0, 19);
                d = $urandom();
                if (s < 12) wr(3'd4, {22'h0, d[0], 5'h0, d[4:1]});
                else if (s < 17) wr(3'($urandom_range(0, 3)), d & 32'hFEFF_FFFF);
                else wr(3'($urandom_range(5, 7)), d);
            end else begin
                logic [47:0] da;
                logic [31:0] crc;
                bit p;
                int k;
                k = $urandom_range(0, 5);
                da = {$urandom(), $urandom()};
                case (k)
                    0: da = m_sta[0];
                    1: da = m_sta[1];
                    2: da = '1;
                    3: da[40] = 1'b1;
                    default: da[40] = 1'b0;
                endcase
                crc = $urandom();
                if ($urandom_range(0, 1) == 0) crc[31:23] = 9'($urandom_range(0, 15));
                p = ($urandom_range(0, 7) == 0);
                case (k)
                    0: look("R5 random", p, da, crc);
                    1: look("R6 random", p, da, crc);
                    2: look("R4 random", p, da, crc);
                    3: look("R7 random", p, da, crc);
                    default: look("R3/R5 random", p, da, crc);
                endcase
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule